// File: doc/BRIEF.md
# Latched Interrupt Priority Arbiter

This block gathers interrupt requests from a set of hardware modules and one software-interrupt request, holds each in a sticky latch, and picks a winner only when the CPU signals that interrupt processing is starting. The winner's number is presented as a constant vector code, and the CPU uses that code to choose which vector to fetch. The pending flag stays high until the CPU acknowledges service.

While a winner is held, no other source can displace it, whatever its priority. The hold ends when the CPU acknowledges service or when the CPU clears its interrupt mask bit. The hardware lines are gated by the mask bit. The software request ignores the mask.

Top module: `irq_latched_arbiter`

## Requirements
- R1: After reset, `irq_pending_o` is 0, `vec_code_o` is 0 and every request latch is empty.
- R2: A request high for a single clock edge is captured in its latch and stays there until its source is serviced. A later arbitration still sees it.
- R3: Arbitration happens only on a clock edge where `arb_start_i` is high and no winner is held. `irq_pending_o` rises on that edge and at no other time.
- R4: While `i_mask_i` is 1, hardware latches take no part in arbitration. The software request (code 0) still wins.
- R5: Priority is fixed and the lowest code wins. The software request has code 0 and hardware line k has code k+1. The winning code appears on `vec_code_o` on the arbitration edge.
- R6: While a winner is held, new requests of any priority and further `arb_start_i` strobes leave `irq_pending_o` high and `vec_code_o` unchanged.
- R7: `svc_ack_i` high while a winner is held clears that winner's latch and drops `irq_pending_o` on the same edge. Other latches keep their requests for the next arbitration.
- R8: A 1-to-0 change of `i_mask_i` while a winner is held releases the hold without clearing any latch. The next strobe re-arbitrates and may pick a higher-priority source.
- R9: A strobe with no eligible request leaves `irq_pending_o` low, and `vec_code_o` keeps its previous value.
- R10: `svc_ack_i` while no winner is held has no effect on the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | N_HW | Hardware request lines; line k has code k+1 |
| swi_req_i | input | 1 | Software interrupt request, non-maskable, code 0 |
| i_mask_i | input | 1 | CPU interrupt mask bit |
| arb_start_i | input | 1 | Start-of-interrupt-processing strobe |
| svc_ack_i | input | 1 | Serviced acknowledge for the held winner |
| irq_pending_o | output | 1 | A winner is held |
| vec_code_o | output | $clog2(N_HW+1) | Code of the held (or last) winner |

## Verification
The arbitration table uses single-line, multi-line, all-lines and software-plus-hardware request patterns, each under both mask states. Mixing the patterns this way separates a wrong priority order from a masking fault and from a software request that is wrongly masked. Directed sequences then raise higher-priority requests while a winner is held, acknowledge and re-strobe to drain the latches one by one, and drop the mask bit mid-hold. These sequences show whether a winner is displaced, whether only the serviced latch is cleared, and whether a release keeps the other requests. Further checks cover an idle strobe and an idle acknowledge, which confirm the code is held and the latches are untouched.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_o[g] <= 1'b0;
      else if (clr_i[g]) lat_o[g] <= 1'b0;
      else if (set_i[g]) lat_o[g] <= 1'b1;
    end

    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_o[g] && !clr_i[g] |=> lat_o[g]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    // scan downward so the lowest index is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  always_comb begin
    if (any_o) a_pick_valid_r5: assert (((req_i >> idx_o) & N'(1)) != '0);
  end
endmodule

// File: rtl/irq_latched_arbiter.sv
module irq_latched_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_HW = 4,
  localparam int N_SRC = N_HW + 1,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_HW-1:0]  hw_req_i,
  input  logic             swi_req_i,
  input  logic             i_mask_i,
  input  logic             arb_start_i,
  input  logic             svc_ack_i,
  output logic             irq_pending_o,
  output logic [VEC_W-1:0] vec_code_o
);
  arb_state_e       state_q;
  logic [VEC_W-1:0] win_q;
  logic             imask_q;
  logic [N_SRC-1:0] lat, elig, clr_vec;
  logic             any_elig, ack_fire, mask_drop;
  logic [VEC_W-1:0] pick_idx;

  assign ack_fire  = (state_q == ARB_HELD) && svc_ack_i;
  assign mask_drop = (state_q == ARB_HELD) && imask_q && !i_mask_i;
  assign clr_vec   = ack_fire ? (N_SRC'(1) << win_q) : '0;

  irq_req_latch #(.N(N_SRC)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({hw_req_i, swi_req_i}),
    .clr_i  (clr_vec),
    .lat_o  (lat)
  );

  // code 0 (software) is never masked
  assign elig = lat & {{N_HW{~i_mask_i}}, 1'b1};

  irq_prio_pick #(.N(N_SRC), .W(VEC_W)) u_pick (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      win_q   <= '0;
      imask_q <= 1'b0;
    end else begin
      imask_q <= i_mask_i;
      unique case (state_q)
        ARB_IDLE: if (arb_start_i && any_elig) begin
          state_q <= ARB_HELD;
          win_q   <= pick_idx;
        end
        ARB_HELD: if (ack_fire || mask_drop) state_q <= ARB_IDLE;
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign irq_pending_o = (state_q == ARB_HELD);
  assign vec_code_o    = win_q;

  p_rise_on_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pending_o) |-> $past(arb_start_i));

  p_masked_swi_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pending_o) && $past(i_mask_i) |-> vec_code_o == '0);

  p_no_displace_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pending_o && !svc_ack_i && !(imask_q && !i_mask_i)
      |=> irq_pending_o && $stable(vec_code_o));

  p_ack_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pending_o && svc_ack_i |=> !irq_pending_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_pending_o |=> irq_pending_o || $stable(vec_code_o));
endmodule

// File: tb/irq_latched_arbiter_tb.sv
module irq_latched_arbiter_tb_top;
  localparam int N_HW  = 4;
  localparam int VEC_W = $clog2(N_HW + 1);

  typedef struct packed {
    logic [N_HW-1:0]  hw;
    logic             swi;
    logic             im;
    logic             pend;
    logic [VEC_W-1:0] vec;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{4'b0001, 1'b0, 1'b0, 1'b1, 3'd1},
    '{4'b1000, 1'b0, 1'b0, 1'b1, 3'd4},
    '{4'b0110, 1'b0, 1'b0, 1'b1, 3'd2},
    '{4'b1010, 1'b1, 1'b0, 1'b1, 3'd0},
    '{4'b1111, 1'b0, 1'b1, 1'b0, 3'd0},
    '{4'b0100, 1'b1, 1'b1, 1'b1, 3'd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 3'd0},
    '{4'b1100, 1'b0, 1'b0, 1'b1, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_HW-1:0] hw_req = '0;
  logic swi_req = 1'b0, i_mask = 1'b0, arb_start = 1'b0, svc_ack = 1'b0;
  logic irq_pending;
  logic [VEC_W-1:0] vec_code;
  int n_chk = 0, n_fail = 0;

  always #5ns clk = ~clk;

  irq_latched_arbiter #(.N_HW(N_HW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hw_req_i(hw_req), .swi_req_i(swi_req),
    .i_mask_i(i_mask), .arb_start_i(arb_start), .svc_ack_i(svc_ack),
    .irq_pending_o(irq_pending), .vec_code_o(vec_code)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; hw_req = '0; swi_req = 1'b0; i_mask = 1'b0;
    arb_start = 1'b0; svc_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic pulse_req(logic [N_HW-1:0] hw, logic swi);
    @(negedge clk); hw_req = hw; swi_req = swi;
    @(negedge clk); hw_req = '0; swi_req = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); arb_start = 1'b1;
    @(negedge clk); arb_start = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); svc_ack = 1'b1;
    @(negedge clk); svc_ack = 1'b0;
  endtask

  initial begin
    #2ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 pending", int'(irq_pending), 0);
    chk("R1 vec", int'(vec_code), 0);
    strobe();
    chk("R1 latches empty", int'(irq_pending), 0);

    // table: one-cycle pulse (R2), then strobe; priority R5, mask R4, empty R9
    for (int k = 0; k < NV; k++) begin
      do_reset();
      @(negedge clk); i_mask = TBL[k].im;
      pulse_req(TBL[k].hw, TBL[k].swi);
      strobe();
      chk($sformatf("R2/R4/R5 pend row %0d", k), int'(irq_pending), int'(TBL[k].pend));
      chk($sformatf("R4/R5/R9 vec row %0d", k), int'(vec_code), int'(TBL[k].vec));
    end

    // R3: latched request without strobe stays unarbitrated
    do_reset();
    pulse_req(4'b0010, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 no strobe", int'(irq_pending), 0);
    strobe();
    chk("R3 strobe pend", int'(irq_pending), 1);
    chk("R3 strobe vec", int'(vec_code), 2);

    // R6/R7: hold against higher priority, then drain by acknowledge
    do_reset();
    pulse_req(4'b0100, 1'b0);
    strobe();
    chk("R6 first win", int'(vec_code), 3);
    pulse_req(4'b0001, 1'b1);
    strobe();
    chk("R6 held pend", int'(irq_pending), 1);
    chk("R6 held vec", int'(vec_code), 3);
    ack();
    chk("R7 ack drops", int'(irq_pending), 0);
    strobe();
    chk("R7 next winner swi", int'(vec_code), 0);
    ack();
    strobe();
    chk("R7 next winner hw0", int'(vec_code), 1);
    ack();
    strobe();
    chk("R7 latches drained pend", int'(irq_pending), 0);
    chk("R9 vec held", int'(vec_code), 1);

    // R8: mask drop releases hold; latches kept
    do_reset();
    pulse_req(4'b0100, 1'b0);
    strobe();
    chk("R8 setup vec", int'(vec_code), 3);
    @(negedge clk); i_mask = 1'b1;
    pulse_req(4'b0001, 1'b0);
    strobe();
    chk("R8 held under mask", int'(vec_code), 3);
    @(negedge clk); i_mask = 1'b0;
    @(negedge clk);
    chk("R8 release", int'(irq_pending), 0);
    strobe();
    chk("R8 rearb pend", int'(irq_pending), 1);
    chk("R8 rearb vec", int'(vec_code), 1);
    ack();
    strobe();
    chk("R8 old winner kept", int'(vec_code), 3);

    // R10: acknowledge while idle leaves latch intact
    do_reset();
    pulse_req(4'b0010, 1'b0);
    ack();
    chk("R10 idle ack pend", int'(irq_pending), 0);
    strobe();
    chk("R10 latch intact pend", int'(irq_pending), 1);
    chk("R10 latch intact vec", int'(vec_code), 2);

    finish_run();
  end
endmodule